// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the controller clock into the time base a CAN protocol engine needs. A 10-bit divider makes a time-quantum tick. A segment sequencer builds each bit from a one-quantum sync segment, a first phase segment and a second phase segment. It marks the transmit point at the end of the sync quantum and the sample point at the end of the first segment.

Two software-visible registers hold the settings. The timing register holds the low prescaler bits, the jump width, and both segment lengths. The extension register holds the upper prescaler bits. Every field is stored as its value minus one. Writes are accepted only while the controller is held in init mode with configuration change enabled. Releasing init starts the timing from the start of a bit.

A recessive-to-dominant edge seen outside the sync quantum resynchronises the bit. A late edge lengthens the first segment and an early edge shortens the second segment. Each correction is limited to the programmed jump width, and only one edge per bit is acted on.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, `timing_o` reads 16'h2300 (prescaler 1, jump width 1, first segment 4 quanta, second segment 3 quanta) and `ext_o` reads 0.
- R2: A write to the timing register (`wr_timing_i`) or the extension register (`wr_ext_i`) takes effect on the next clock edge only when `init_i` and `cfg_en_i` are both 1. Otherwise the stored values and their read-back are unchanged. The timing register keeps `wr_data_i[14:0]` and reads bit 15 as 0. The extension register keeps `wr_data_i[3:0]`.
- R3: While `init_i` is 1, `tq_tick_o`, `sample_o` and `tx_point_o` stay 0 and all timing counters are held at the start of a bit.
- R4: With `init_i` at 0, `tq_tick_o` pulses once every P clocks, where P = {ext[3:0], timing[5:0]} + 1 (1 to 1024). The first pulse comes P clocks after `init_i` falls.
- R5: Without resynchronisation, a bit lasts 1 + T1 + T2 quanta, with T1 = timing[11:8] + 1 and T2 = timing[14:12] + 1. `tx_point_o` pulses with the tick that ends the sync quantum.
- R6: `sample_o` pulses with the tick that ends the first segment, and never in the same cycle as `tx_point_o`.
- R7: An accepted edge during the first segment, while its quantum counter is q, lengthens that segment by min(SJW, q+1) quanta, where SJW = timing[7:6] + 1.
- R8: An accepted edge during the second segment, while its quantum counter is q, shortens that segment by min(SJW, T2-1-q) quanta.
- R9: An edge during the sync quantum causes no adjustment. Only the first edge in a bit is acted on, and edges after it are ignored until the bit ends.
- R10: A first-segment field of 0 is treated as 2 quanta, the minimum length of that segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock (50 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Init mode: 1 holds the timing, 0 runs it |
| cfg_en_i | input | 1 | Configuration change enable |
| wr_timing_i | input | 1 | Write strobe for the timing register |
| wr_ext_i | input | 1 | Write strobe for the prescaler extension register |
| wr_data_i | input | 16 | Write data |
| rx_edge_i | input | 1 | One-cycle pulse on a recessive-to-dominant bus edge |
| timing_o | output | 16 | Timing register read-back |
| ext_o | output | 4 | Extension register read-back |
| tq_tick_o | output | 1 | Time-quantum tick |
| sample_o | output | 1 | Sample point pulse |
| tx_point_o | output | 1 | Transmit point pulse (end of the sync quantum) |

## Verification
The bench runs a reference model next to the design and compares every cycle. It covers a divide-by-two setting with mid-sized segments, a divider that uses the extension bits, and the smallest legal bit. Together these separate errors in the divider from errors in segment counting and in the clamp on the first segment. Single edges placed just after the transmit point and just after the sample point show whether the first segment grows and the second segment shrinks by the expected amounts. A second edge in the same bit must change nothing. Writes with only one of the two unlock conditions set, and reads of the unused timing bit, test the lock.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int DATA_W    = 16;
  localparam int BRP_LO_W  = 6;
  localparam int BRP_HI_W  = 4;
  localparam int BRP_W     = BRP_LO_W + BRP_HI_W;
  localparam int SJW_W     = 2;
  localparam int TS1_W     = 4;
  localparam int TS2_W     = 3;
  localparam int TIM_W     = BRP_LO_W + SJW_W + TS1_W + TS2_W;
  localparam int SJW_LSB   = BRP_LO_W;
  localparam int TS1_LSB   = SJW_LSB + SJW_W;
  localparam int TS2_LSB   = TS1_LSB + TS1_W;
  localparam int TS1_MIN   = 2;
  localparam int SJW_LW    = SJW_W + 1;
  localparam int SEG1_LW   = TS1_W + 1;
  localparam int SEG2_LW   = TS2_W + 1;
  localparam int QCNT_W    = SEG1_LW + 1;

  typedef enum logic [1:0] {PH_SYNC, PH_SEG1, PH_SEG2} phase_e;

  typedef struct packed {
    logic [BRP_W-1:0]   brp;
    logic [SJW_LW-1:0]  sjw_len;
    logic [SEG1_LW-1:0] seg1_len;
    logic [SEG2_LW-1:0] seg2_len;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs
  import can_bt_pkg::*;
#(
  parameter logic [TIM_W-1:0] RST_TIMING = TIM_W'(16'h2300)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                cfg_en_i,
  input  logic                wr_timing_i,
  input  logic                wr_ext_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [TIM_W-1:0]    timing_q_o,
  output logic [BRP_HI_W-1:0] ext_q_o,
  output bt_cfg_t             cfg_o
);
  logic               unlocked;
  logic [SEG1_LW-1:0] seg1_raw;

  assign unlocked = init_i & cfg_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q_o <= RST_TIMING;
      ext_q_o    <= '0;
    end else if (unlocked) begin
      if (wr_timing_i) timing_q_o <= wr_data_i[TIM_W-1:0];
      if (wr_ext_i)    ext_q_o    <= wr_data_i[BRP_HI_W-1:0];
    end
  end

  // fields are stored minus one
  assign seg1_raw = SEG1_LW'(timing_q_o[TS1_LSB +: TS1_W]) + SEG1_LW'(1);

  always_comb begin
    cfg_o.brp      = {ext_q_o, timing_q_o[BRP_LO_W-1:0]};
    cfg_o.sjw_len  = SJW_LW'(timing_q_o[SJW_LSB +: SJW_W]) + SJW_LW'(1);
    cfg_o.seg1_len = (seg1_raw < SEG1_LW'(TS1_MIN)) ? SEG1_LW'(TS1_MIN) : seg1_raw;
    cfg_o.seg2_len = SEG2_LW'(timing_q_o[TS2_LSB +: TS2_W]) + SEG2_LW'(1);
  end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + BRP_W'(1);
  end
endmodule

// File: rtl/can_bt_segment.sv
module can_bt_segment
  import can_bt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    tick_i,
  input  logic    edge_i,
  input  bt_cfg_t cfg_i,
  output logic    sample_o,
  output logic    tx_point_o
);
  phase_e             phase_q, phase_d;
  logic [QCNT_W-1:0]  qcnt_q, qcnt_d;
  logic [SJW_LW-1:0]  adj_q, adj_d;
  logic               done_q, done_d;

  logic [QCNT_W-1:0]  sjw_l, seg1_l, seg2_l, q_inc, rem_m1, adj_new, adj_now;
  logic               accept, seg1_end, seg2_end, bit_end, step;

  assign sjw_l  = QCNT_W'(cfg_i.sjw_len);
  assign seg1_l = QCNT_W'(cfg_i.seg1_len);
  assign seg2_l = QCNT_W'(cfg_i.seg2_len);
  assign q_inc  = qcnt_q + QCNT_W'(1);
  assign rem_m1 = seg2_l - QCNT_W'(1) - qcnt_q;

  // one resync per bit
  assign accept = run_i && edge_i && !done_q;

  always_comb begin
    unique case (phase_q)
      PH_SEG1: adj_new = (sjw_l < q_inc)  ? sjw_l : q_inc;
      PH_SEG2: adj_new = (sjw_l < rem_m1) ? sjw_l : rem_m1;
      default: adj_new = '0;
    endcase
  end

  // an edge takes effect in its own cycle, also when a tick coincides
  assign adj_now  = accept ? adj_new : QCNT_W'(adj_q);
  assign seg1_end = (qcnt_q == seg1_l - QCNT_W'(1) + adj_now);
  assign seg2_end = (qcnt_q == seg2_l - QCNT_W'(1) - adj_now);

  assign tx_point_o = tick_i && (phase_q == PH_SYNC);
  assign sample_o   = tick_i && (phase_q == PH_SEG1) && seg1_end;
  assign bit_end    = tick_i && (phase_q == PH_SEG2) && seg2_end;
  assign step       = tx_point_o || sample_o || bit_end;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_SYNC: if (tx_point_o) phase_d = PH_SEG1;
      PH_SEG1: if (sample_o)   phase_d = PH_SEG2;
      PH_SEG2: if (bit_end)    phase_d = PH_SYNC;
      default:                 phase_d = PH_SYNC;
    endcase
    if (step)        qcnt_d = '0;
    else if (tick_i) qcnt_d = q_inc;
    else             qcnt_d = qcnt_q;
    adj_d  = step ? '0 : SJW_LW'(adj_now);
    done_d = bit_end ? 1'b0 : (done_q | accept);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      qcnt_q  <= '0;
      adj_q   <= '0;
      done_q  <= 1'b0;
    end else if (!run_i) begin
      phase_q <= PH_SYNC;
      qcnt_q  <= '0;
      adj_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      qcnt_q  <= qcnt_d;
      adj_q   <= adj_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        cfg_en_i,
  input  logic        wr_timing_i,
  input  logic        wr_ext_i,
  input  logic [15:0] wr_data_i,
  input  logic        rx_edge_i,
  output logic [15:0] timing_o,
  output logic [3:0]  ext_o,
  output logic        tq_tick_o,
  output logic        sample_o,
  output logic        tx_point_o
);
  logic [TIM_W-1:0]    timing_q;
  logic [BRP_HI_W-1:0] ext_q;
  bt_cfg_t             cfg;
  logic                run;
  logic                tick;

  assign run = ~init_i;

  can_bt_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .cfg_en_i    (cfg_en_i),
    .wr_timing_i (wr_timing_i),
    .wr_ext_i    (wr_ext_i),
    .wr_data_i   (wr_data_i),
    .timing_q_o  (timing_q),
    .ext_q_o     (ext_q),
    .cfg_o       (cfg)
  );

  can_bt_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .brp_i  (cfg.brp),
    .tick_o (tick)
  );

  can_bt_segment u_seg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .edge_i     (rx_edge_i),
    .cfg_i      (cfg),
    .sample_o   (sample_o),
    .tx_point_o (tx_point_o)
  );

  assign timing_o  = {{(DATA_W-TIM_W){1'b0}}, timing_q};
  assign ext_o     = ext_q;
  assign tq_tick_o = tick;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_i,
  input logic        cfg_en_i,
  input logic        wr_timing_i,
  input logic        wr_ext_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] timing_o,
  input logic [3:0]  ext_o,
  input logic        tq_tick_o,
  input logic        sample_o,
  input logic        tx_point_o
);
  // R3
  idle_in_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> !(tq_tick_o || sample_o || tx_point_o));

  // R2
  locked_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_timing_i && !(init_i && cfg_en_i)) |=> $stable(timing_o));

  // R2
  locked_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ext_i && !(init_i && cfg_en_i)) |=> $stable(ext_o));

  // R2
  open_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_timing_i && init_i && cfg_en_i) |=> (timing_o == {1'b0, $past(wr_data_i[14:0])}));

  // R6
  sample_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (tq_tick_o && !tx_point_o));

  // R5
  tx_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_point_o |-> tq_tick_o);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .cfg_en_i    (cfg_en_i),
  .wr_timing_i (wr_timing_i),
  .wr_ext_i    (wr_ext_i),
  .wr_data_i   (wr_data_i),
  .timing_o    (timing_o),
  .ext_o       (ext_o),
  .tq_tick_o   (tq_tick_o),
  .sample_o    (sample_o),
  .tx_point_o  (tx_point_o)
);

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b1;
  logic        cfg_en_i = 1'b0;
  logic        wr_timing_i = 1'b0;
  logic        wr_ext_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        rx_edge_i = 1'b0;
  logic [15:0] timing_o;
  logic [3:0]  ext_o;
  logic        tq_tick_o, sample_o, tx_point_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  can_bit_timer dut (.*);

  // reference model state
  int m_tim, m_ext, m_pc, m_ph, m_qc, m_adj, m_done;
  bit e_tick, e_smp, e_tx;
  int n_pc, n_ph, n_qc, n_adj, n_done;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_eval();
    int brp, sjw, s1, s2, adjn, adjnow;
    bit run, acc, e1, e2, bend;
    run = !init_i;
    brp = m_ext * 64 + (m_tim & 63);
    sjw = ((m_tim >> 6) & 3) + 1;
    s1  = ((m_tim >> 8) & 15) + 1;
    if (s1 < 2) s1 = 2;
    s2  = ((m_tim >> 12) & 7) + 1;
    e_tick = run && (m_pc == brp);
    acc = run && rx_edge_i && (m_done == 0);
    adjn = (m_ph == 1) ? imin(sjw, m_qc + 1) : (m_ph == 2) ? imin(sjw, s2 - 1 - m_qc) : 0;
    adjnow = acc ? adjn : m_adj;
    e1 = (m_qc == s1 - 1 + adjnow);
    e2 = (m_qc == s2 - 1 - adjnow);
    e_tx  = e_tick && m_ph == 0;
    e_smp = e_tick && m_ph == 1 && e1;
    bend  = e_tick && m_ph == 2 && e2;
    if (!run) begin
      n_pc = 0; n_ph = 0; n_qc = 0; n_adj = 0; n_done = 0;
    end else begin
      n_pc = e_tick ? 0 : m_pc + 1;
      n_ph = m_ph; n_qc = m_qc; n_adj = adjnow;
      if (e_tx || e_smp || bend) begin
        n_ph = (m_ph + 1) % 3; n_qc = 0; n_adj = 0;
      end else if (e_tick) n_qc = m_qc + 1;
      n_done = bend ? 0 : ((acc || m_done != 0) ? 1 : 0);
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_tim = 16'h2300; m_ext = 0; m_pc = 0; m_ph = 0; m_qc = 0; m_adj = 0; m_done = 0;
    end else begin
      model_eval();
      m_pc = n_pc; m_ph = n_ph; m_qc = n_qc; m_adj = n_adj; m_done = n_done;
      if (init_i && cfg_en_i) begin
        if (wr_timing_i) m_tim = wr_data_i & 16'h7fff;
        if (wr_ext_i)    m_ext = wr_data_i & 4'hf;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      model_eval();
      chk(tq_tick_o == e_tick, "R4", "tq_tick", tq_tick_o, e_tick);
      chk(tx_point_o == e_tx, "R5", "tx_point", tx_point_o, e_tx);
      chk(sample_o == e_smp, "R6", "sample", sample_o, e_smp);
      chk(timing_o == m_tim[15:0], "R2", "timing_o", timing_o, m_tim);
      chk(ext_o == m_ext[3:0], "R2", "ext_o", ext_o, m_ext);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic configure(logic [15:0] tim, logic [3:0] ext);
    init_i = 1; cfg_en_i = 1; step();
    wr_data_i = tim; wr_timing_i = 1; step(); wr_timing_i = 0;
    wr_data_i = {12'h0, ext}; wr_ext_i = 1; step(); wr_ext_i = 0;
    cfg_en_i = 0; init_i = 0; step();
  endtask

  task automatic wait_tx();
    do @(negedge clk_i); while (!tx_point_o);
  endtask
  task automatic wait_smp();
    do @(negedge clk_i); while (!sample_o);
  endtask
  task automatic wait_tick();
    do @(negedge clk_i); while (!tq_tick_o);
  endtask

  task automatic pulse_edge();
    @(posedge clk_i); #1 rx_edge_i = 1;
    @(posedge clk_i); #1 rx_edge_i = 0;
  endtask

  initial begin
    int t0, cnt;
    step(3);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk(timing_o == 16'h2300, "R1", "reset timing_o", timing_o, 16'h2300);
    chk(ext_o == 4'h0, "R1", "reset ext_o", ext_o, 0);

    // R2: locked writes
    init_i = 1; cfg_en_i = 0; step();
    wr_data_i = 16'h1234; wr_timing_i = 1; wr_ext_i = 1; step();
    init_i = 0; cfg_en_i = 1; step();
    wr_timing_i = 0; wr_ext_i = 0; init_i = 1; cfg_en_i = 0; step();
    @(negedge clk_i);
    chk(timing_o == 16'h2300, "R2", "locked timing write", timing_o, 16'h2300);
    chk(ext_o == 4'h0, "R2", "locked ext write", ext_o, 0);
    cfg_en_i = 1; step();
    wr_data_i = 16'hffff; wr_timing_i = 1; wr_ext_i = 1; step();
    wr_timing_i = 0; wr_ext_i = 0; step();
    @(negedge clk_i);
    chk(timing_o == 16'h7fff, "R2", "open timing write bit15", timing_o, 16'h7fff);
    chk(ext_o == 4'hf, "R2", "open ext write", ext_o, 4'hf);

    // R3: quiet in init
    cnt = 0;
    repeat (30) begin
      @(negedge clk_i);
      if (tq_tick_o || sample_o || tx_point_o) cnt++;
    end
    chk(cnt == 0, "R3", "pulses during init", cnt, 0);

    // brp=1 (2 clk/tq), sjw=2, T1=4, T2=3 -> 8 tq per bit
    configure(16'h2341, 4'h0);
    wait_tx(); t0 = cyc; wait_tx();
    chk(cyc - t0 == 16, "R5", "bit length no edge", cyc - t0, 16);
    wait_smp(); t0 = cyc; wait_tx();
    chk(cyc - t0 == 8, "R6", "sample to tx", cyc - t0, 8);

    // R7: late edge at first quantum of seg1 -> +1 tq
    wait_tx(); t0 = cyc; pulse_edge(); wait_tx();
    chk(cyc - t0 == 18, "R7", "seg1 lengthened", cyc - t0, 18);

    // R9: second edge in same bit ignored
    wait_tx(); t0 = cyc; pulse_edge(); step(3); rx_edge_i = 1; step(); rx_edge_i = 0; wait_tx();
    chk(cyc - t0 == 18, "R9", "second edge ignored", cyc - t0, 18);

    // R8: early edge at first quantum of seg2 -> seg2 cut to 1 tq
    wait_smp(); t0 = cyc; pulse_edge(); wait_tx();
    chk(cyc - t0 == 4, "R8", "seg2 shortened", cyc - t0, 4);

    // R9: edge in sync quantum: no change
    wait_smp(); step(5); rx_edge_i = 1; step(); rx_edge_i = 0;
    wait_tx(); t0 = cyc; wait_tx();
    chk(cyc - t0 == 16, "R9", "bit after sync edge", cyc - t0, 16);

    // R4: prescaler with extension bits -> 65 clk per tq
    configure(16'h2300, 4'h1);
    wait_tick(); t0 = cyc; wait_tick();
    chk(cyc - t0 == 65, "R4", "tq period with ext", cyc - t0, 65);

    // R10: all fields zero -> 1+2+1 tq at 1 clk/tq
    configure(16'h0000, 4'h0);
    wait_tx(); t0 = cyc; wait_tx();
    chk(cyc - t0 == 4, "R10", "seg1 clamp bit length", cyc - t0, 4);

    // R3: back to init halts output
    init_i = 1; step();
    cnt = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (tq_tick_o || sample_o || tx_point_o) cnt++;
    end
    chk(cnt == 0, "R3", "pulses after re-entering init", cnt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule